// File: doc/BRIEF.md
# Four-Channel Phase-Accumulating Cosine Synthesizer Core

This core holds four direct-synthesis channels that all run on one system clock. Each channel owns a phase accumulator. Every clock the accumulator adds that channel's frequency word. A per-channel phase offset is added to the top of the accumulated phase. The sum indexes a quarter-wave cosine table, and the signed result is multiplied by a per-channel amplitude word. Each channel produces one signed 10-bit sample per clock, and the sample is meant to drive a converter.

The frequency, offset and amplitude words arrive as already-active values on parallel buses, one slice per channel. A single mode input chooses how their changes line up. In the short mode each word reaches the output as fast as its own path allows: amplitude first, then offset, then frequency. In the aligned mode the two faster paths are padded, so a change of any kind shows at the output on the same cycle as a frequency change. Because every channel has the same pipeline and one clock, the channels stay in lockstep.

Top module: `dds_quad_engine`

## Requirements
- R1: Each channel keeps a 32-bit accumulator that adds its frequency word every clock, modulo 2^32. The phase is (accumulator bits 31..18) + offset, taken modulo 2^14. The table address p is bits 13..2 of that phase.
- R2: The cosine value for a 12-bit address p is 511·cos(2π(p+0.5)/4096), rounded to the nearest integer with ties away from zero. The table stores one quarter of the wave and rebuilds the other three quadrants by symmetry.
- R3: The sample is (cosine · A) / 1024, rounded toward zero. A is the 10-bit amplitude word read as unsigned. The sample is a 10-bit two's-complement value and lies within ±510.
- R4: With the mode input low, count from the rising edge that first samples a new word. A frequency word shows in the sample registered 4 edges later, an offset word 3 edges later, and an amplitude word 1 edge later.
- R5: With the mode input high, all three kinds of word show in the sample registered 4 edges after the capturing edge. The mode is applied per clock, at the pipeline stage that consumes each word.
- R6: Reset is synchronous and active high. It clears every accumulator, every sample, every captured frequency word and every captured or delayed offset word to zero. It sets every captured or delayed amplitude word to full scale (1023).
- R7: Channel c uses bits [c·32 +: 32] of the frequency bus, [c·14 +: 14] of the offset bus, [c·10 +: 10] of the amplitude bus and [c·10 +: 10] of the sample bus. Channels do not affect one another. Channels that are given identical words produce identical samples on the same cycle.
- R8: An amplitude word of zero forces that channel's sample to zero, whatever the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common system clock |
| rst | input | 1 | Synchronous active-high reset |
| match_en_i | input | 1 | High selects the aligned-latency mode |
| ftw_i | input | 128 | Frequency words, 32 bits per channel |
| poff_i | input | 56 | Phase offset words, 14 bits per channel |
| amp_i | input | 40 | Amplitude words, 10 bits per channel, unsigned |
| smp_o | output | 40 | Signed samples, 10 bits per channel |

## Verification
The bench changes the words at chosen cycles in both modes and also flips the mode in the middle of a run. A design with a pad register too many or too few in the offset or amplitude path would show the new value one cycle early or late. One step of 2^20 walks the full circle, so every quadrant boundary of the table is visited, and a wrong mirror or sign in the symmetry logic would produce a wrong or discontinuous value there. The amplitude values 0, 1, 512 and 1023 are paired with negative cosine values, and a product truncated toward minus infinity would come out one step too negative. Channels given equal words are compared against each other, and channels given different words reveal any crossed slice.

// File: rtl/dds_quad_pkg.sv
`timescale 1ns/1ps
package dds_quad_pkg;

    localparam int NCH_DEF    = 4;
    localparam int ACC_W_DEF  = 32;
    localparam int POFF_W_DEF = 14;
    localparam int AMP_W_DEF  = 10;
    localparam int SMP_W_DEF  = 10;
    localparam int LUT_PW_DEF = 12;

    // Register stages from each word's capture register to the sample register
    localparam int STG_FREQ  = 4;
    localparam int STG_PHASE = 3;
    localparam int STG_AMP   = 1;
    localparam int PAD_PHASE = STG_FREQ - STG_PHASE;
    localparam int PAD_AMP   = STG_FREQ - STG_AMP;

    typedef enum logic {
        LAT_SHORT   = 1'b0,
        LAT_ALIGNED = 1'b1
    } lat_mode_e;

    // One quarter-wave table entry, sampled half a step off the grid so
    // that every quadrant is an exact mirror of the first one.
    function automatic int qtr_cos(input int idx, input int qbits, input int peak);
        real two_pi;
        real th;
        real v;
        two_pi = 6.283185307179586;
        th = two_pi * (real'(idx) + 0.5) / real'(4 * (1 << qbits));
        v  = real'(peak) * $cos(th);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        else
            return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/dds_tap_delay.sv
`timescale 1ns/1ps
module dds_tap_delay #(
    parameter int           W       = 10,
    parameter int           DEPTH   = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         long_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = long_i ? stage_q[DEPTH-1] : d_i;

endmodule

// File: rtl/dds_cos_quarter.sv
`timescale 1ns/1ps
module dds_cos_quarter
    import dds_quad_pkg::*;
#(
    parameter int LUT_PW = 12,
    parameter int SMP_W  = 10
) (
    input  logic [LUT_PW-1:0]       phase_i,
    output logic signed [SMP_W-1:0] cos_o
);

    localparam int QW   = LUT_PW - 2;
    localparam int QN   = 1 << QW;
    localparam int PEAK = (1 << (SMP_W - 1)) - 1;

    logic signed [SMP_W-1:0] tab [QN];

    for (genvar i = 0; i < QN; i++) begin : g_tab
        localparam int ENTRY = qtr_cos(i, QW, PEAK);
        assign tab[i] = SMP_W'(ENTRY);
    end

    logic [1:0]              quad;
    logic [QW-1:0]           idx;
    logic [QW-1:0]           rd_idx;
    logic                    negate;
    logic signed [SMP_W-1:0] mag;

    assign quad   = phase_i[LUT_PW-1 -: 2];
    assign idx    = phase_i[QW-1:0];
    // odd quadrants run the table backwards, the middle two are negated
    assign rd_idx = quad[0] ? ~idx : idx;
    assign negate = quad[1] ^ quad[0];
    assign mag    = tab[rd_idx];
    assign cos_o  = negate ? -mag : mag;

endmodule

// File: rtl/dds_channel.sv
`timescale 1ns/1ps
module dds_channel
    import dds_quad_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int POFF_W = 14,
    parameter int AMP_W  = 10,
    parameter int SMP_W  = 10,
    parameter int LUT_PW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  lat_mode_e         mode_i,
    input  logic [ACC_W-1:0]  ftw_i,
    input  logic [POFF_W-1:0] poff_i,
    input  logic [AMP_W-1:0]  amp_i,
    output logic [SMP_W-1:0]  smp_o
);

    localparam int PROD_W = SMP_W + AMP_W + 1;
    localparam logic [AMP_W-1:0] AMP_FULL = '1;

    typedef struct packed {
        logic [ACC_W-1:0]  ftw;
        logic [POFF_W-1:0] poff;
        logic [AMP_W-1:0]  amp;
    } chan_word_t;

    chan_word_t              cap_q;
    logic [ACC_W-1:0]        acc_q;
    logic [LUT_PW-1:0]       ph_q;
    logic signed [SMP_W-1:0] cos_q;
    logic [SMP_W-1:0]        smp_q;

    logic [POFF_W-1:0]       poff_sel;
    logic [AMP_W-1:0]        amp_sel;
    logic [POFF_W-1:0]       ph_sum;
    logic signed [SMP_W-1:0] cos_d;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_b;
    logic                    long_sel;

    assign long_sel = (mode_i == LAT_ALIGNED);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q.ftw  <= '0;
            cap_q.poff <= '0;
            cap_q.amp  <= AMP_FULL;
        end else begin
            cap_q.ftw  <= ftw_i;
            cap_q.poff <= poff_i;
            cap_q.amp  <= amp_i;
        end
    end

    dds_tap_delay #(.W(POFF_W), .DEPTH(PAD_PHASE), .RST_VAL('0)) u_poff_pad (
        .clk    (clk),
        .rst    (rst),
        .long_i (long_sel),
        .d_i    (cap_q.poff),
        .q_o    (poff_sel)
    );

    dds_tap_delay #(.W(AMP_W), .DEPTH(PAD_AMP), .RST_VAL(AMP_FULL)) u_amp_pad (
        .clk    (clk),
        .rst    (rst),
        .long_i (long_sel),
        .d_i    (cap_q.amp),
        .q_o    (amp_sel)
    );

    assign ph_sum = acc_q[ACC_W-1 -: POFF_W] + poff_sel;

    dds_cos_quarter #(.LUT_PW(LUT_PW), .SMP_W(SMP_W)) u_cos (
        .phase_i (ph_q),
        .cos_o   (cos_d)
    );

    // round toward zero: bias negative products by 2^AMP_W - 1 before the shift
    assign prod   = cos_q * $signed({1'b0, amp_sel});
    assign prod_b = prod + $signed({{(SMP_W + 1){1'b0}}, {AMP_W{prod[PROD_W-1]}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ph_q  <= '0;
            cos_q <= '0;
            smp_q <= '0;
        end else begin
            acc_q <= acc_q + cap_q.ftw;
            ph_q  <= ph_sum[POFF_W-1 -: LUT_PW];
            cos_q <= cos_d;
            smp_q <= prod_b[AMP_W +: SMP_W];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{ph_sum[POFF_W-LUT_PW-1:0], prod_b[PROD_W-1], prod_b[AMP_W-1:0]};

    assign smp_o = smp_q;

endmodule

// File: rtl/dds_quad_engine.sv
`timescale 1ns/1ps
module dds_quad_engine
    import dds_quad_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int POFF_W = POFF_W_DEF,
    parameter int AMP_W  = AMP_W_DEF,
    parameter int SMP_W  = SMP_W_DEF,
    parameter int LUT_PW = LUT_PW_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  match_en_i,
    input  logic [NCH*ACC_W-1:0]  ftw_i,
    input  logic [NCH*POFF_W-1:0] poff_i,
    input  logic [NCH*AMP_W-1:0]  amp_i,
    output logic [NCH*SMP_W-1:0]  smp_o
);

    lat_mode_e mode;
    assign mode = match_en_i ? LAT_ALIGNED : LAT_SHORT;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dds_channel #(
            .ACC_W  (ACC_W),
            .POFF_W (POFF_W),
            .AMP_W  (AMP_W),
            .SMP_W  (SMP_W),
            .LUT_PW (LUT_PW)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .mode_i (mode),
            .ftw_i  (ftw_i[c*ACC_W +: ACC_W]),
            .poff_i (poff_i[c*POFF_W +: POFF_W]),
            .amp_i  (amp_i[c*AMP_W +: AMP_W]),
            .smp_o  (smp_o[c*SMP_W +: SMP_W])
        );
    end

endmodule

// File: rtl/dds_quad_engine_chk.sv
`timescale 1ns/1ps
module dds_quad_engine_chk #(
    parameter int NCH    = 4,
    parameter int ACC_W  = 32,
    parameter int POFF_W = 14,
    parameter int AMP_W  = 10,
    parameter int SMP_W  = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  match_en_i,
    input logic [NCH*ACC_W-1:0]  ftw_i,
    input logic [NCH*POFF_W-1:0] poff_i,
    input logic [NCH*AMP_W-1:0]  amp_i,
    input logic [NCH*SMP_W-1:0]  smp_o
);

    localparam int SMP_LIM = (((1 << (SMP_W - 1)) - 1) * ((1 << AMP_W) - 1)) / (1 << AMP_W);

    logic [1:0] age_q;
    logic       same_q;
    logic       in_eq;
    logic       out_eq;

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    always_comb begin
        in_eq  = 1'b1;
        out_eq = 1'b1;
        for (int c = 1; c < NCH; c++) begin
            if (ftw_i[c*ACC_W +: ACC_W] != ftw_i[ACC_W-1:0]) in_eq = 1'b0;
            if (poff_i[c*POFF_W +: POFF_W] != poff_i[POFF_W-1:0]) in_eq = 1'b0;
            if (amp_i[c*AMP_W +: AMP_W] != amp_i[AMP_W-1:0]) in_eq = 1'b0;
            if (smp_o[c*SMP_W +: SMP_W] != smp_o[SMP_W-1:0]) out_eq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) same_q <= 1'b1;
        else     same_q <= same_q & in_eq;
    end

    // R6
    reset_zero_chk: assert property (@(posedge clk) rst |=> (smp_o == '0));

    // R7
    lockstep_chk: assert property (@(posedge clk) disable iff (rst) same_q |-> out_eq);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8
        amp_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd2 && !$past(match_en_i) && $past(amp_i[c*AMP_W +: AMP_W], 2) == '0)
            |-> (smp_o[c*SMP_W +: SMP_W] == '0));

        // R3
        sample_bound_chk: assert property (@(posedge clk) disable iff (rst)
            ($signed(smp_o[c*SMP_W +: SMP_W]) <= SMP_LIM) &&
            ($signed(smp_o[c*SMP_W +: SMP_W]) >= -SMP_LIM));
    end

endmodule

bind dds_quad_engine dds_quad_engine_chk #(
    .NCH    (NCH),
    .ACC_W  (ACC_W),
    .POFF_W (POFF_W),
    .AMP_W  (AMP_W),
    .SMP_W  (SMP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .match_en_i (match_en_i),
    .ftw_i      (ftw_i),
    .poff_i     (poff_i),
    .amp_i      (amp_i),
    .smp_o      (smp_o)
);

// File: tb/test_dds_quad_engine.sv
`timescale 1ns/1ps
module test_dds_quad_engine;

    localparam int NC   = 4;
    localparam int FW   = 32;
    localparam int PW   = 14;
    localparam int AW   = 10;
    localparam int SW   = 10;
    localparam int HMAX = 8192;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              match_en = 1'b0;
    logic [NC*FW-1:0]  ftw  = '0;
    logic [NC*PW-1:0]  poff = '0;
    logic [NC*AW-1:0]  amp  = '0;
    logic [NC*SW-1:0]  smp;

    always #4 clk = ~clk;

    dds_quad_engine i_dds_quad_engine (
        .clk        (clk),
        .rst        (rst),
        .match_en_i (match_en),
        .ftw_i      (ftw),
        .poff_i     (poff),
        .amp_i      (amp),
        .smp_o      (smp)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int               t;
        logic [NC*SW-1:0] exp;
        string            tag;
    } item_t;
    item_t sbq [$];

    int unsigned fh  [NC][HMAX];
    int          ph  [NC][HMAX];
    int          ah  [NC][HMAX];
    bit          sh  [HMAX];
    int unsigned cum [NC][HMAX+1];
    int          tcur;
    string       seg_tag;
    int unsigned rng = 32'h1234_5678;

    function automatic int unsigned next_rnd();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    function automatic int hp(int c, int k);
        return (k < 0) ? 0 : ph[c][k];
    endfunction
    function automatic int ha(int c, int k);
        return (k < 0) ? 1023 : ah[c][k];
    endfunction
    function automatic bit hs(int k);
        return (k < 0) ? 1'b0 : sh[k];
    endfunction
    function automatic int unsigned hacc(int c, int k);
        return (k <= 0) ? 0 : cum[c][k];
    endfunction

    // expected sample for channel c registered at edge t (edges counted from reset release)
    function automatic int model(int c, int t);
        int unsigned a;
        int psel, asel, phs, p12, cv;
        real th;
        a    = hacc(c, t - 3);
        psel = hs(t - 2) ? hp(c, t - 4) : hp(c, t - 3);
        asel = hs(t) ? ha(c, t - 4) : ha(c, t - 1);
        phs  = (int'(a >> 18) + psel) & 16383;
        p12  = phs >> 2;
        th   = 6.283185307179586 * (real'(p12) + 0.5) / 4096.0;
        cv   = int'(511.0 * $cos(th));
        return (cv * asel) / 1024;
    endfunction

    task automatic do_reset(input string tag);
        while (sbq.size() > 0) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        n_chk++;
        if (smp !== '0) begin
            n_bad++;
            $display("FAIL R6 reset sample got %h exp 0", smp);
        end
        seg_tag = tag;
        tcur = 0;
        for (int c = 0; c < NC; c++) cum[c][0] = 0;
        rst = 1'b0;
    endtask

    task automatic drive(input logic [NC*FW-1:0] f, input logic [NC*PW-1:0] p,
                         input logic [NC*AW-1:0] a, input bit m);
        item_t it;
        ftw = f; poff = p; amp = a; match_en = m;
        sh[tcur] = m;
        for (int c = 0; c < NC; c++) begin
            fh[c][tcur] = f[c*FW +: FW];
            ph[c][tcur] = int'(p[c*PW +: PW]);
            ah[c][tcur] = int'(a[c*AW +: AW]);
            cum[c][tcur+1] = cum[c][tcur] + fh[c][tcur];
        end
        if (tcur >= 2) begin
            it.t = tcur;
            it.tag = seg_tag;
            for (int c = 0; c < NC; c++) it.exp[c*SW +: SW] = SW'(model(c, tcur));
            sbq.push_back(it);
        end
        @(negedge clk);
        tcur++;
    endtask

    // monitor: compares each registered sample with the scoreboard head
    initial begin
        int  ecount;
        bit  rs;
        item_t it;
        ecount = 0;
        forever begin
            @(posedge clk);
            rs = rst;
            #2;
            if (rs) begin
                ecount = 0;
            end else begin
                if (sbq.size() > 0 && sbq[0].t == ecount) begin
                    it = sbq.pop_front();
                    n_chk++;
                    for (int c = 0; c < NC; c++) begin
                        if (smp[c*SW +: SW] !== it.exp[c*SW +: SW]) begin
                            n_bad++;
                            $display("FAIL %s t=%0d ch%0d got %0d exp %0d", it.tag, it.t, c,
                                     $signed(smp[c*SW +: SW]), $signed(it.exp[c*SW +: SW]));
                        end
                    end
                    if (it.tag == "R7") begin
                        n_chk++;
                        for (int c = 1; c < NC; c++)
                            if (smp[c*SW +: SW] !== smp[SW-1:0]) begin
                                n_bad++;
                                $display("FAIL R7 lockstep t=%0d ch%0d got %0d exp %0d", it.t, c,
                                         $signed(smp[c*SW +: SW]), $signed(smp[SW-1:0]));
                            end
                    end
                end
                ecount++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired got hang exp completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [NC*FW-1:0] f;
        logic [NC*PW-1:0] p;
        logic [NC*AW-1:0] a;
        int unsigned r;
        int ch;

        repeat (3) @(negedge clk);

        // R1 R2: full-circle walk on ch0, other steps on other channels
        do_reset("R1 R2");
        f = {32'h8000_0000, 32'hFFF0_0000, 32'h0123_4567, 32'h0010_0000};
        p = {14'd16383, 14'd8191, 14'd5, 14'd0};
        a = {4{10'd1023}};
        for (int i = 0; i < 4300; i++) drive(f, p, a, 1'b0);

        // R4: stepped words, short mode
        do_reset("R4");
        f = {32'h0300_0000, 32'h0004_0000, 32'h1000_0001, 32'h0055_0000};
        p = '0;
        a = {4{10'd700}};
        for (int i = 0; i < 400; i++) begin
            if (i % 6 == 0) begin
                r = next_rnd();
                ch = int'(r % NC);
                case ((r >> 4) % 3)
                    0: f[ch*FW +: FW] = next_rnd();
                    1: p[ch*PW +: PW] = PW'(next_rnd());
                    default: a[ch*AW +: AW] = AW'(next_rnd());
                endcase
            end
            drive(f, p, a, 1'b0);
        end

        // R5: stepped words, aligned mode
        do_reset("R5");
        for (int i = 0; i < 400; i++) begin
            if (i % 5 == 0) begin
                r = next_rnd();
                ch = int'(r % NC);
                case ((r >> 4) % 3)
                    0: f[ch*FW +: FW] = next_rnd();
                    1: p[ch*PW +: PW] = PW'(next_rnd());
                    default: a[ch*AW +: AW] = AW'(next_rnd());
                endcase
            end
            drive(f, p, a, 1'b1);
        end

        // R5: mode flipped mid-run while words keep changing
        do_reset("R5");
        for (int i = 0; i < 300; i++) begin
            if (i % 3 == 0) begin
                f[(i % NC)*FW +: FW] = next_rnd();
                p[((i + 1) % NC)*PW +: PW] = PW'(next_rnd());
                a[((i + 2) % NC)*AW +: AW] = AW'(next_rnd());
            end
            drive(f, p, a, ((i / 9) % 2) == 1);
        end

        // R3 R8: corner amplitudes across negative and positive cosine
        do_reset("R3 R8");
        f = {32'h0700_0000, 32'h0A00_0000, 32'hF100_0000, 32'h0040_0000};
        p = {14'd4096, 14'd8192, 14'd12000, 14'd3};
        for (int i = 0; i < 240; i++) begin
            for (int c = 0; c < NC; c++) begin
                case (((i / 20) + c) % 4)
                    0: a[c*AW +: AW] = 10'd0;
                    1: a[c*AW +: AW] = 10'd1;
                    2: a[c*AW +: AW] = 10'd512;
                    default: a[c*AW +: AW] = 10'd1023;
                endcase
            end
            drive(f, p, a, (i >= 120));
        end

        // R7: identical words on every channel
        do_reset("R7");
        for (int i = 0; i < 300; i++) begin
            if (i % 4 == 0) begin
                f = {4{next_rnd()}};
                p = {4{PW'(next_rnd())}};
                a = {4{AW'(next_rnd())}};
            end
            drive(f, p, a, (i % 50) > 25);
        end

        while (sbq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule